// File: doc/BRIEF.md
# Radix-2 FFT Engine on a Single Dual-Port Memory

This block computes an N-point radix-2 decimation-in-frequency FFT on signed 16-bit complex samples. All working data stays in one dual-port memory of exactly N complex words, with no second buffer. While idle, the host writes the N time-domain samples through a load port. It then pulses `start`. The engine runs log2N stages and raises `done` for one cycle. The spectrum is then read back through an unload port, addressed by frequency bin.

Each memory port reads one word per cycle and writes the previous butterfly's result back to that same word in the same cycle. Results therefore land one butterfly position away from the usual in-place slot. An address map records where every logical value currently lives, and it is updated with the same read-then-overwrite rhythm. A stage costs N/2 butterfly issues plus one flush cycle. The flush cycle stores the last pair into the slots of the stage's first butterfly. Every butterfly output is halved, so the result equals the DFT divided by N.

Top module: `fft_r2_dpmem`

## Requirements
- R1: While `busy` is low, `ld_en` high at a clock edge stores (`ld_re`, `ld_im`) as time sample number `ld_idx` (0..N-1).
- R2: `start` while idle makes `busy` high from the next cycle. `busy` then stays high for exactly (N/2+1)·log2N cycles (36 for N=16).
- R3: `done` is high for exactly one cycle, which is the first cycle after `busy` falls.
- R4: After `done`, bin k reads back as (1/N)·Σn x[n]·e^(-j2πnk/N) for each of the real and imaginary parts. The tolerance is ±6 LSB, provided the outputs stay within range.
- R5: `rd_en` with bin index `rd_bin` while idle gives `rd_valid` high one cycle later, with that bin's value on `rd_re`/`rd_im`.
- R6: `ld_en` while `busy` is high is ignored. The transform result is unchanged.
- R7: `rd_en` while `busy` is high is refused. `rd_valid` is low in the following cycle.
- R8: `start` while `busy` is high is ignored. The run length and the single `done` pulse are unchanged.
- R9: Transforms may be repeated. Each new load followed by `start` gives the correct spectrum of the new samples, whatever earlier runs left in the address map.
- R10: While `rst` is held high at a clock edge, `busy`, `done` and `rd_valid` are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe for one time sample |
| ld_idx | input | log2N | Time index of the sample being loaded |
| ld_re | input | 16 | Sample real part, two's complement |
| ld_im | input | 16 | Sample imaginary part, two's complement |
| start | input | 1 | Begin a transform |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | input | 1 | Unload request |
| rd_bin | input | log2N | Frequency bin to read |
| rd_valid | output | 1 | Unload data valid |
| rd_re | output | 16 | Bin real part |
| rd_im | output | 16 | Bin imaginary part |

## Verification
The bench uses two single impulses, one at sample 0 and one at sample 3. The first gives a flat spectrum. The second adds a linear phase, which exposes any slip in the load index or the bin ordering. A complex constant puts all energy in bin 0. A real cosine at bin 3 splits its energy between bins 3 and 13. A complex exponential at bin 5 occupies a single bin and so checks the sign of the twiddles. A pseudo-random block exercises every twiddle and every remapped address with non-trivial data. The cosine run also drives load, unload and start in the middle of the transform, to show that each is refused.

// File: rtl/fft_r2_pkg.sv
package fft_r2_pkg;

  localparam int SAMPLE_W = 16;
  localparam int PROD_W   = 2 * SAMPLE_W + 2;
  localparam int WIDE_W   = SAMPLE_W + 2;

  typedef struct packed {
    logic signed [SAMPLE_W-1:0] re;
    logic signed [SAMPLE_W-1:0] im;
  } cplx_t;

  // Q1.15 cosine (sel=0) or sine (sel=1) of 2*pi*m/n, evaluated at elaboration
  function automatic logic signed [SAMPLE_W-1:0] tw_q15(input int m, input int n, input bit sel);
    real ang, term, c, s, v;
    int  r;
    ang  = 2.0 * 3.14159265358979 * real'(m) / real'(n);
    c    = 0.0;
    s    = 0.0;
    term = 1.0;
    for (int i = 0; i < 26; i++) begin
      case (i % 4)
        0: c = c + term;
        1: s = s + term;
        2: c = c - term;
        default: s = s - term;
      endcase
      term = term * ang / real'(i + 1);
    end
    v = sel ? s : c;
    if (v >= 0.0) r = $rtoi(v * 32767.0 + 0.5);
    else          r = -$rtoi(-v * 32767.0 + 0.5);
    return r[SAMPLE_W-1:0];
  endfunction

  function automatic logic signed [SAMPLE_W-1:0] sat_s(input logic signed [WIDE_W-1:0] v);
    if (v > WIDE_W'(32767))       return 16'sh7fff;
    else if (v < -WIDE_W'(32768)) return 16'sh8000;
    else                          return v[SAMPLE_W-1:0];
  endfunction

endpackage

// File: rtl/fft_dpram.sv
module fft_dpram #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic [AW-1:0] addr_a,
  input  logic          we_a,
  input  logic [DW-1:0] wd_a,
  output logic [DW-1:0] q_a,
  input  logic [AW-1:0] addr_b,
  input  logic          we_b,
  input  logic [DW-1:0] wd_b,
  output logic [DW-1:0] q_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first on both ports: a same-address write lands after the old word is read
  always_ff @(posedge clk) begin
    if (we_a) mem[addr_a] <= wd_a;
    if (we_b) mem[addr_b] <= wd_b;
    q_a <= mem[addr_a];
    q_b <= mem[addr_b];
  end
endmodule

// File: rtl/fft_bfly.sv
module fft_bfly
  import fft_r2_pkg::*;
#(
  parameter int N = 16
) (
  input  cplx_t                        a,
  input  cplx_t                        b,
  input  logic [$clog2(N)-2:0]         tw_idx,
  output cplx_t                        x,
  output cplx_t                        y
);
  localparam int HALFN = N / 2;

  logic signed [SAMPLE_W-1:0] tw_re [HALFN];
  logic signed [SAMPLE_W-1:0] tw_im [HALFN];

  for (genvar m = 0; m < HALFN; m++) begin : g_tw
    localparam logic signed [SAMPLE_W-1:0] C_RE = tw_q15(m, N, 1'b0);
    localparam logic signed [SAMPLE_W-1:0] C_SN = tw_q15(m, N, 1'b1);
    assign tw_re[m] = C_RE;
    assign tw_im[m] = -C_SN;
  end

  logic signed [SAMPLE_W:0] sr, si, dr, di;
  logic signed [SAMPLE_W-1:0] wr, wi;
  logic signed [PROD_W-1:0] pr, pi;

  always_comb begin
    wr = tw_re[tw_idx];
    wi = tw_im[tw_idx];
    sr = (SAMPLE_W+1)'(a.re) + (SAMPLE_W+1)'(b.re);
    si = (SAMPLE_W+1)'(a.im) + (SAMPLE_W+1)'(b.im);
    dr = (SAMPLE_W+1)'(a.re) - (SAMPLE_W+1)'(b.re);
    di = (SAMPLE_W+1)'(a.im) - (SAMPLE_W+1)'(b.im);
    pr = PROD_W'(dr) * PROD_W'(wr) - PROD_W'(di) * PROD_W'(wi);
    pi = PROD_W'(dr) * PROD_W'(wi) + PROD_W'(di) * PROD_W'(wr);
    x.re = SAMPLE_W'(sr >>> 1);
    x.im = SAMPLE_W'(si >>> 1);
    y.re = sat_s(WIDE_W'(pr >>> SAMPLE_W));
    y.im = sat_s(WIDE_W'(pi >>> SAMPLE_W));
  end
endmodule

// File: rtl/fft_agen.sv
module fft_agen #(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [$clog2(N)-1:0] unl_bin,
  output logic                 run,
  output logic                 done,
  output logic [$clog2(N)-1:0] phys_a,
  output logic [$clog2(N)-1:0] phys_b,
  output logic                 wr_en,
  output logic [$clog2(N)-2:0] tw_idx,
  output logic [$clog2(N)-1:0] unl_phys
);
  localparam int AW    = $clog2(N);
  localparam int TIW   = AW - 1;
  localparam int HALFN = N / 2;
  localparam int SCW   = (AW > 1) ? $clog2(AW) : 1;

  logic [AW-1:0]  map_q [N];
  logic [SCW-1:0] stage_q;
  logic [AW-1:0]  slot_q;
  logic [AW-1:0]  prev_a_q, prev_b_q;
  logic [AW-1:0]  sav_a_q, sav_b_q;
  logic [TIW-1:0] tw_q;

  logic [SCW-1:0] hsh;
  logic [AW-1:0]  jx, halfv, kx, la, lb, rbin;
  logic [TIW-1:0] tw_next;
  logic           last;

  // logical pair of butterfly j in the current stage (decimation in frequency)
  always_comb begin
    hsh     = SCW'(AW - 1) - stage_q;
    jx      = {1'b0, slot_q[AW-2:0]};
    halfv   = AW'(1) << hsh;
    kx      = jx & (halfv - AW'(1));
    la      = (((jx >> hsh) << hsh) << 1) | kx;
    lb      = la | halfv;
    tw_next = TIW'(kx << stage_q);
    last    = (slot_q == AW'(HALFN));
    for (int i = 0; i < AW; i++) rbin[i] = unl_bin[AW-1-i];
  end

  assign phys_a   = last ? sav_a_q : map_q[la];
  assign phys_b   = last ? sav_b_q : map_q[lb];
  assign wr_en    = run && (slot_q != '0);
  assign tw_idx   = tw_q;
  assign unl_phys = map_q[rbin];

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      done     <= 1'b0;
      stage_q  <= '0;
      slot_q   <= '0;
      prev_a_q <= '0;
      prev_b_q <= '0;
      sav_a_q  <= '0;
      sav_b_q  <= '0;
      tw_q     <= '0;
      for (int i = 0; i < N; i++) map_q[i] <= AW'(i);
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          run     <= 1'b1;
          stage_q <= '0;
          slot_q  <= '0;
          for (int i = 0; i < N; i++) map_q[i] <= AW'(i);
        end
      end else begin
        prev_a_q <= la;
        prev_b_q <= lb;
        tw_q     <= tw_next;
        if (slot_q == '0) begin
          sav_a_q <= map_q[la];
          sav_b_q <= map_q[lb];
        end else if (!last) begin
          map_q[prev_a_q] <= map_q[la];
          map_q[prev_b_q] <= map_q[lb];
        end else begin
          map_q[prev_a_q] <= sav_a_q;
          map_q[prev_b_q] <= sav_b_q;
        end
        if (last) begin
          slot_q <= '0;
          if (stage_q == SCW'(AW - 1)) begin
            run  <= 1'b0;
            done <= 1'b1;
          end else begin
            stage_q <= stage_q + SCW'(1);
          end
        end else begin
          slot_q <= slot_q + AW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fft_r2_dpmem.sv
module fft_r2_dpmem
  import fft_r2_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_en,
  input  logic [$clog2(N)-1:0]  ld_idx,
  input  logic [SAMPLE_W-1:0]   ld_re,
  input  logic [SAMPLE_W-1:0]   ld_im,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  input  logic                  rd_en,
  input  logic [$clog2(N)-1:0]  rd_bin,
  output logic                  rd_valid,
  output logic [SAMPLE_W-1:0]   rd_re,
  output logic [SAMPLE_W-1:0]   rd_im
);
  localparam int AW  = $clog2(N);
  localparam int TIW = AW - 1;
  localparam int DW  = 2 * SAMPLE_W;

  logic [AW-1:0]  phys_a, phys_b, unl_phys;
  logic [AW-1:0]  addr_a, addr_b;
  logic           wr_en, we_b;
  logic [TIW-1:0] tw_idx;
  cplx_t          q_a, q_b, bx, by;
  logic [DW-1:0]  wd_b;
  logic           rv_q;

  fft_agen #(.N(N)) u_agen (
    .clk(clk), .rst(rst), .start(start), .unl_bin(rd_bin),
    .run(busy), .done(done), .phys_a(phys_a), .phys_b(phys_b),
    .wr_en(wr_en), .tw_idx(tw_idx), .unl_phys(unl_phys)
  );

  fft_bfly #(.N(N)) u_bfly (
    .a(q_a), .b(q_b), .tw_idx(tw_idx), .x(bx), .y(by)
  );

  assign addr_a = busy ? phys_a : unl_phys;
  assign addr_b = busy ? phys_b : ld_idx;
  assign we_b   = busy ? wr_en  : ld_en;
  assign wd_b   = busy ? by     : {ld_re, ld_im};

  fft_dpram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk),
    .addr_a(addr_a), .we_a(wr_en), .wd_a(bx), .q_a(q_a),
    .addr_b(addr_b), .we_b(we_b), .wd_b(wd_b), .q_b(q_b)
  );

  always_ff @(posedge clk) begin
    if (rst) rv_q <= 1'b0;
    else     rv_q <= rd_en && !busy;
  end

  assign rd_valid = rv_q;
  assign rd_re    = q_a.re;
  assign rd_im    = q_a.im;
endmodule

// File: rtl/fft_r2_dpmem_chk.sv
module fft_r2_dpmem_chk #(
  parameter int N = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 rd_valid,
  input logic [$clog2(N)-1:0] addr_a,
  input logic [$clog2(N)-1:0] addr_b
);
  localparam int LEN = (N / 2 + 1) * $clog2(N);

  logic [15:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 16'd1;
    else           run_cnt <= '0;
  end

  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r2_busy_len: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(busy)) |-> (run_cnt == 16'(LEN)));

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r7_no_unload_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> !rd_valid);

  // R4: the two ports always touch two different words during a stage
  a_r4_ports_distinct: assert property (@(posedge clk) disable iff (rst)
    busy |-> (addr_a != addr_b));
endmodule

bind fft_r2_dpmem fft_r2_dpmem_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .rd_valid(rd_valid), .addr_a(addr_a), .addr_b(addr_b)
);

// File: tb/fft_r2_dpmem_bench.sv
module fft_r2_dpmem_bench;
  localparam int N   = 16;
  localparam int AW  = 4;
  localparam int LEN = (N / 2 + 1) * AW;
  localparam real TOL = 6.0;
  localparam real PI  = 3.14159265358979;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_en = 1'b0, start = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] ld_idx = '0, rd_bin = '0;
  logic [15:0]   ld_re = '0, ld_im = '0;
  logic          busy, done, rd_valid;
  logic [15:0]   rd_re, rd_im;

  int n_chk = 0;
  int n_fail = 0;
  int xr [N];
  int xi [N];

  always #4 clk = ~clk;

  fft_r2_dpmem #(.N(N)) u_fft_r2_dpmem (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_re(ld_re), .ld_im(ld_im),
    .start(start), .busy(busy), .done(done), .rd_en(rd_en), .rd_bin(rd_bin),
    .rd_valid(rd_valid), .rd_re(rd_re), .rd_im(rd_im)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic load_all();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = AW'(i);
      ld_re = 16'(xr[i]); ld_im = 16'(xi[i]);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // disturb: mid-run load, unload and start attempts (R6, R7, R8)
  task automatic run_fft(input bit disturb);
    int cyc;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
    cyc = 0;
    while (busy === 1'b1 && cyc < 1000) begin
      cyc++;
      if (disturb && cyc == 5) begin
        ld_en = 1'b1; ld_idx = '0; ld_re = 16'h7000; ld_im = 16'h9000;
        rd_en = 1'b1; rd_bin = 4'd2; start = 1'b1;
      end
      if (disturb && cyc == 6) begin
        ld_en = 1'b0; rd_en = 1'b0; start = 1'b0;
        check(rd_valid === 1'b0, "R7", "rd_valid while busy", int'(rd_valid), 0);
      end
      @(negedge clk);
    end
    check(cyc == LEN, disturb ? "R8" : "R2", "busy cycles", cyc, LEN);
    check(done === 1'b1, "R3", "done after busy", int'(done), 1);
    @(negedge clk);
    check(done === 1'b0, "R3", "done one cycle", int'(done), 0);
  endtask

  task automatic unload_check(input string tag);
    for (int k = 0; k < N; k++) begin
      real er, ei;
      er = 0.0; ei = 0.0;
      for (int n = 0; n < N; n++) begin
        real th;
        th = 2.0 * PI * real'(n * k) / real'(N);
        er = er + real'(xr[n]) * $cos(th) + real'(xi[n]) * $sin(th);
        ei = ei + real'(xi[n]) * $cos(th) - real'(xr[n]) * $sin(th);
      end
      er = er / real'(N);
      ei = ei / real'(N);
      @(negedge clk); rd_en = 1'b1; rd_bin = AW'(k);
      @(negedge clk); rd_en = 1'b0;
      check(rd_valid === 1'b1, "R5", "rd_valid", int'(rd_valid), 1);
      check((real'($signed(rd_re)) - er) <= TOL && (er - real'($signed(rd_re))) <= TOL,
            tag, $sformatf("bin %0d re", k), int'($signed(rd_re)), $rtoi(er));
      check((real'($signed(rd_im)) - ei) <= TOL && (ei - real'($signed(rd_im))) <= TOL,
            tag, $sformatf("bin %0d im", k), int'($signed(rd_im)), $rtoi(ei));
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    repeat (4) @(negedge clk);
    check(busy === 1'b0, "R10", "busy in reset", int'(busy), 0);
    check(done === 1'b0, "R10", "done in reset", int'(done), 0);
    check(rd_valid === 1'b0, "R10", "rd_valid in reset", int'(rd_valid), 0);
    rst = 1'b0;

    // impulse at sample 0: flat spectrum
    for (int i = 0; i < N; i++) begin xr[i] = 0; xi[i] = 0; end
    xr[0] = 8000;
    load_all(); run_fft(1'b0); unload_check("R1 R4 impulse0");

    // impulse at sample 3: linear phase exposes index placement
    for (int i = 0; i < N; i++) begin xr[i] = 0; xi[i] = 0; end
    xr[3] = 8000;
    load_all(); run_fft(1'b0); unload_check("R1 R9 impulse3");

    // complex constant: bin 0 only
    for (int i = 0; i < N; i++) begin xr[i] = 1000; xi[i] = 500; end
    load_all(); run_fft(1'b0); unload_check("R4 dc");

    // real cosine at bin 3, with mid-run disturbance
    for (int i = 0; i < N; i++) begin
      xr[i] = $rtoi(6000.0 * $cos(2.0 * PI * 3.0 * real'(i) / real'(N)));
      xi[i] = 0;
    end
    load_all(); run_fft(1'b1); unload_check("R6 R4 cosine");

    // complex exponential at bin 5: twiddle sign
    for (int i = 0; i < N; i++) begin
      xr[i] = $rtoi(7000.0 * $cos(2.0 * PI * 5.0 * real'(i) / real'(N)));
      xi[i] = $rtoi(7000.0 * $sin(2.0 * PI * 5.0 * real'(i) / real'(N)));
    end
    load_all(); run_fft(1'b0); unload_check("R4 cexp5");

    // pseudo-random block
    seed = 32'h1234_5678;
    for (int i = 0; i < N; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      xr[i] = int'(seed[30:16] % 15'd8001) - 4000;
      seed = seed * 32'd1103515245 + 32'd12345;
      xi[i] = int'(seed[30:16] % 15'd8001) - 4000;
    end
    load_all(); run_fft(1'b0); unload_check("R9 R4 random");

    finish_run();
  end
endmodule